// File: doc/BRIEF.md
# Masked Header Match Router

This block decides where each received cell goes by looking at its four routing header octets. A 32-bit header word comes with a valid strobe and a verdict from the header checksum logic. The word is compared with five programmable pattern pairs. Four pairs belong to output ports and one describes idle filler cells. Each pair holds a value and a mask, and a mask bit set to 1 makes that header bit take part in the comparison. One cycle after the strobe the block reports one of three results: a one-hot port select, an idle flag, or a no-match flag. Cells that fail the checksum are dropped without any result.

The block also counts results: one counter per port, one idle counter and one no-match counter. All counters sit behind the same small register interface as the patterns. Reading a counter clears it. Counters stop at all-ones, and the block raises a one-cycle overflow pulse on the increment that reaches that value. Storing cell payloads and queuing them per port are handled elsewhere.

Top module: `hdr_route_top`

## Requirements
- R1: A header bit is compared with the pattern value only where the pattern mask bit is 1; a bit whose mask bit is 0 never affects the result.
- R2: The idle pattern is tested before the port patterns: a cell matching idle sets idleHit and no port bit, even if it also matches a port.
- R3: When several ports match and idle does not, only the lowest-numbered matching port is selected in portSel (bit p means port p).
- R4: A checksum-good cell that matches neither idle nor any port sets noMatch.
- R5: A cell strobed with hecOk low produces no result (matchValid stays low) and changes no counter.
- R6: The result appears on the clock edge after the strobe. While matchValid is high, exactly one of portSel, idleHit and noMatch is set; otherwise all three are zero.
- R7: Counters count accepted cells: port p at address 16+p, idle at address 20, no-match at address 21, each 16 bits.
- R8: A read (regRdEn) returns its data on regRdData one cycle later. Reading a counter clears it, and other counters are not affected.
- R9: Counters stop at 0xFFFF. The increment that reaches 0xFFFF pulses cntOvfl for one cycle: bits 0..3 for the ports, bit 4 for idle, bit 5 for no-match.
- R10: If a counter is read in the same cycle it is incremented, the read returns the old value and the counter is left at 1.
- R11: After reset all masks are 0xFFFFFFFF, all values are 0 and all counters are 0, so a header of 0 is idle and any other header is a no-match.
- R12: Pattern registers are written and read back at these addresses: port p value at p, port p mask at 4+p, idle value at 8, idle mask at 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Header word strobe, one cycle per cell |
| hdrWord | input | 32 | The four routing header octets |
| hecOk | input | 1 | Header checksum verdict for this cell |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 5 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid one cycle after regRdEn |
| matchValid | output | 1 | A routing result is present |
| portSel | output | 4 | One-hot selected port |
| idleHit | output | 1 | Cell matched the idle pattern |
| noMatch | output | 1 | Cell matched nothing |
| cntOvfl | output | 6 | Counter saturation pulses |

## Verification
The hardest condition to reach from the ports is saturation. A counter has to receive 65535 increments before the overflow pulse can appear, and the following increment must leave the value at 0xFFFF. The bench programs an idle pattern and streams idle cells back to back, one per cycle. It confirms that no pulse appears on the first 65534 cells, that the pulse appears on the next cell only, and that the counter then reads 0xFFFF. A second hard case is a read that lands in the same cycle as an increment. The bench drives the strobe and the read on one edge to reach it.

// File: rtl/hdr_route_pkg.sv
package hdr_route_pkg;
  localparam int NUM_PORTS = 4;
  localparam int HDR_W     = 32;
  localparam int CNT_W     = 16;
  localparam int ADDR_W    = 5;
  localparam int NUM_CNT   = NUM_PORTS + 2;
  localparam int IDLE_IDX  = NUM_PORTS;
  localparam int NONE_IDX  = NUM_PORTS + 1;
  localparam int MASK_BASE = NUM_PORTS;
  localparam int IDLE_VAL_ADDR  = 2 * NUM_PORTS;
  localparam int IDLE_MASK_ADDR = 2 * NUM_PORTS + 1;
  localparam int CNT_BASE  = 16;

  // Strobes from control to datapath: one increment request per counter.
  typedef struct packed {
    logic [NUM_CNT-1:0] bump;
  } strobeT;
endpackage

// File: rtl/hdr_route_ctrl.sv
module hdr_route_ctrl
  import hdr_route_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            hdrValid,
  input  logic                            hecOk,
  input  logic [HDR_W-1:0]                hdrWord,
  input  logic [NUM_PORTS-1:0][HDR_W-1:0] portVal,
  input  logic [NUM_PORTS-1:0][HDR_W-1:0] portMask,
  input  logic [HDR_W-1:0]                idleVal,
  input  logic [HDR_W-1:0]                idleMask,
  output strobeT                          strobe,
  output logic                            matchValid,
  output logic [NUM_PORTS-1:0]            portSel,
  output logic                            idleHit,
  output logic                            noMatch
);
  logic [NUM_PORTS-1:0] portHit;
  logic [NUM_PORTS-1:0] firstHit;
  logic                 anyHit;
  logic                 idleMatch;
  logic                 cellGo;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cmp
      assign portHit[p] = ((hdrWord ^ portVal[p]) & portMask[p]) == '0;
    end
  endgenerate

  assign idleMatch = ((hdrWord ^ idleVal) & idleMask) == '0;
  assign cellGo    = hdrValid && hecOk;

  // Lowest-numbered matching port wins.
  always_comb begin
    firstHit = '0;
    anyHit   = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (portHit[p] && !anyHit) begin
        firstHit[p] = 1'b1;
        anyHit      = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.bump = '0;
    if (cellGo) begin
      if (idleMatch)   strobe.bump[IDLE_IDX] = 1'b1;
      else if (anyHit) strobe.bump[NUM_PORTS-1:0] = firstHit;
      else             strobe.bump[NONE_IDX] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchValid <= 1'b0;
      portSel    <= '0;
      idleHit    <= 1'b0;
      noMatch    <= 1'b0;
    end else begin
      matchValid <= cellGo;
      portSel    <= strobe.bump[NUM_PORTS-1:0];
      idleHit    <= strobe.bump[IDLE_IDX];
      noMatch    <= strobe.bump[NONE_IDX];
    end
  end
endmodule

// File: rtl/hdr_route_dp.sv
module hdr_route_dp
  import hdr_route_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  strobeT                          strobe,
  input  logic                            regWrEn,
  input  logic                            regRdEn,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [HDR_W-1:0]                regWrData,
  output logic [HDR_W-1:0]                regRdData,
  output logic [NUM_PORTS-1:0][HDR_W-1:0] portVal,
  output logic [NUM_PORTS-1:0][HDR_W-1:0] portMask,
  output logic [HDR_W-1:0]                idleVal,
  output logic [HDR_W-1:0]                idleMask,
  output logic [NUM_CNT-1:0]              cntOvfl
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0]            cntRdHit;
  logic [HDR_W-1:0]              rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portVal  <= '0;
      portMask <= '1;
      idleVal  <= '0;
      idleMask <= '1;
    end else if (regWrEn) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (regAddr == ADDR_W'(p))             portVal[p]  <= regWrData;
        if (regAddr == ADDR_W'(MASK_BASE + p)) portMask[p] <= regWrData;
      end
      if (regAddr == ADDR_W'(IDLE_VAL_ADDR))  idleVal  <= regWrData;
      if (regAddr == ADDR_W'(IDLE_MASK_ADDR)) idleMask <= regWrData;
    end
  end

  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      assign cntRdHit[i] = regRdEn && (regAddr == ADDR_W'(CNT_BASE + i));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          cnt[i]     <= '0;
          cntOvfl[i] <= 1'b0;
        end else begin
          cntOvfl[i] <= 1'b0;
          if (cntRdHit[i]) begin
            cnt[i] <= strobe.bump[i] ? CNT_W'(1) : '0;
          end else if (strobe.bump[i] && cnt[i] != CNT_MAX) begin
            cnt[i]     <= cnt[i] + 1'b1;
            cntOvfl[i] <= (cnt[i] == CNT_MAX - 1'b1);
          end
        end
      end
    end
  endgenerate

  always_comb begin
    rdNext = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (regAddr == ADDR_W'(p))             rdNext = portVal[p];
      if (regAddr == ADDR_W'(MASK_BASE + p)) rdNext = portMask[p];
    end
    if (regAddr == ADDR_W'(IDLE_VAL_ADDR))  rdNext = idleVal;
    if (regAddr == ADDR_W'(IDLE_MASK_ADDR)) rdNext = idleMask;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (regAddr == ADDR_W'(CNT_BASE + i)) rdNext = HDR_W'(cnt[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= rdNext;
  end
endmodule

// File: rtl/hdr_route_top.sv
module hdr_route_top
  import hdr_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hdrValid,
  input  logic [HDR_W-1:0]     hdrWord,
  input  logic                 hecOk,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [HDR_W-1:0]     regWrData,
  output logic [HDR_W-1:0]     regRdData,
  output logic                 matchValid,
  output logic [NUM_PORTS-1:0] portSel,
  output logic                 idleHit,
  output logic                 noMatch,
  output logic [NUM_CNT-1:0]   cntOvfl
);
  strobeT                          strobe;
  logic [NUM_PORTS-1:0][HDR_W-1:0] portVal;
  logic [NUM_PORTS-1:0][HDR_W-1:0] portMask;
  logic [HDR_W-1:0]                idleVal;
  logic [HDR_W-1:0]                idleMask;

  hdr_route_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hecOk(hecOk), .hdrWord(hdrWord),
    .portVal(portVal), .portMask(portMask), .idleVal(idleVal), .idleMask(idleMask),
    .strobe(strobe), .matchValid(matchValid), .portSel(portSel),
    .idleHit(idleHit), .noMatch(noMatch)
  );

  hdr_route_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .portVal(portVal), .portMask(portMask), .idleVal(idleVal), .idleMask(idleMask),
    .cntOvfl(cntOvfl)
  );
endmodule

// File: rtl/hdr_route_chk.sv
module hdr_route_chk
  import hdr_route_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 hdrValid,
  input logic                 hecOk,
  input logic                 matchValid,
  input logic [NUM_PORTS-1:0] portSel,
  input logic                 idleHit,
  input logic                 noMatch,
  input logic [NUM_CNT-1:0]   cntOvfl
);
  p_single_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |-> $countones({portSel, idleHit, noMatch}) == 1);

  p_quiet_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    !matchValid |-> ({portSel, idleHit, noMatch} == '0));

  p_result_follows_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |-> $past(hdrValid && hecOk));

  p_hec_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && !hecOk) |=> (!matchValid && cntOvfl == '0));

  p_ovfl_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cntOvfl));

  p_ovfl_with_result_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cntOvfl != '0) |-> (matchValid &&
      (cntOvfl[NUM_PORTS-1:0] & ~portSel) == '0 &&
      (!cntOvfl[IDLE_IDX] || idleHit) && (!cntOvfl[NONE_IDX] || noMatch)));
endmodule

bind hdr_route_top hdr_route_chk u_chk (
  .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hecOk(hecOk),
  .matchValid(matchValid), .portSel(portSel), .idleHit(idleHit),
  .noMatch(noMatch), .cntOvfl(cntOvfl)
);

// File: tb/hdr_route_top_test.sv
module hdr_route_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hdrValid = 1'b0;
  logic [31:0] hdrWord = '0;
  logic        hecOk = 1'b1;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        matchValid;
  logic [3:0]  portSel;
  logic        idleHit;
  logic        noMatch;
  logic [5:0]  cntOvfl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hdr_route_top uut (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrWord(hdrWord), .hecOk(hecOk),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .matchValid(matchValid), .portSel(portSel),
    .idleHit(idleHit), .noMatch(noMatch), .cntOvfl(cntOvfl)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  // Result packed as {matchValid, noMatch, idleHit, portSel}
  task automatic sendCell(input logic [31:0] h, input bit good, output logic [6:0] res);
    @(negedge clk);
    hdrValid = 1'b1; hdrWord = h; hecOk = good;
    @(negedge clk);
    hdrValid = 1'b0; hecOk = 1'b1;
    res = {matchValid, noMatch, idleHit, portSel};
  endtask

  task automatic clearCounters();
    logic [31:0] d;
    for (int i = 16; i < 22; i++) rdReg(5'(i), d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [6:0]  r;
    check({matchValid, portSel, idleHit, noMatch, cntOvfl} == '0, "R11 outputs", 32'(portSel), 0);
    rdReg(5'd5, d);  check(d == 32'hFFFF_FFFF, "R11 port1 mask", d, 32'hFFFF_FFFF);
    rdReg(5'd2, d);  check(d == 0, "R11 port2 value", d, 0);
    rdReg(5'd16, d); check(d == 0, "R11 counter", d, 0);
    sendCell(32'h0, 1, r);        check(r == 7'b1010000, "R11 zero header idle", 32'(r), 32'h50);
    sendCell(32'h0000_0001, 1, r); check(r == 7'b1100000, "R4 nonmatch after reset", 32'(r), 32'h60);
    rdReg(5'd20, d); check(d == 1, "R7 idle count", d, 1);
    rdReg(5'd21, d); check(d == 1, "R7 nonmatch count", d, 1);
    rdReg(5'd21, d); check(d == 0, "R8 cleared on read", d, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    logic [6:0]  r;
    wrReg(5'd8, 32'h1234_5678);
    wrReg(5'd0, 32'h00AB_0000); wrReg(5'd4, 32'h00FF_0000);
    wrReg(5'd1, 32'hF000_0001); wrReg(5'd2, 32'hF000_0002); wrReg(5'd3, 32'hF000_0003);
    rdReg(5'd4, d); check(d == 32'h00FF_0000, "R12 mask readback", d, 32'h00FF_0000);
    rdReg(5'd8, d); check(d == 32'h1234_5678, "R12 idle value readback", d, 32'h1234_5678);
    sendCell(32'h11AB_2233, 1, r); check(r == 7'b1000001, "R1 masked bits ignored", 32'(r), 32'h41);
    sendCell(32'h11AC_2233, 1, r); check(r == 7'b1100000, "R1 unmasked bit differs", 32'(r), 32'h60);
    sendCell(32'hF000_0003, 1, r); check(r == 7'b1001000, "R1 full mask port3", 32'(r), 32'h48);
  endtask

  task automatic t_priority();
    logic [6:0] r;
    wrReg(5'd1, 32'h00AB_0000); wrReg(5'd5, 32'h00FF_0000);
    wrReg(5'd6, 32'h0);
    sendCell(32'h00AB_0000, 1, r); check(r == 7'b1000001, "R3 lowest port wins", 32'(r), 32'h41);
    sendCell(32'h00CD_0000, 1, r); check(r == 7'b1000100, "R3 catch-all port2", 32'(r), 32'h44);
    wrReg(5'd9, 32'h0);
    sendCell(32'h00AB_0000, 1, r); check(r == 7'b1010000, "R2 idle before ports", 32'(r), 32'h50);
    wrReg(5'd9, 32'hFFFF_FFFF);
    wrReg(5'd6, 32'hFFFF_FFFF);
  endtask

  task automatic t_counts();
    logic [31:0] d;
    logic [6:0]  r;
    clearCounters();
    for (int i = 0; i < 3; i++) sendCell(32'h00AB_0000, 1, r);
    sendCell(32'hF000_0002, 1, r); sendCell(32'hF000_0002, 1, r);
    sendCell(32'h1234_5678, 1, r);
    sendCell(32'h00AB_0000, 0, r); check(r == 7'b0, "R5 bad checksum no result", 32'(r), 0);
    sendCell(32'h1234_5678, 0, r); sendCell(32'h5555_5555, 0, r);
    rdReg(5'd16, d); check(d == 3, "R7 port0 count excludes bad checksum R5", d, 3);
    rdReg(5'd17, d); check(d == 0, "R7 port1 count", d, 0);
    rdReg(5'd18, d); check(d == 2, "R7 port2 count", d, 2);
    rdReg(5'd20, d); check(d == 1, "R7 idle count", d, 1);
    rdReg(5'd21, d); check(d == 0, "R5 nonmatch untouched", d, 0);
    rdReg(5'd16, d); check(d == 0, "R8 port0 cleared", d, 0);
    rdReg(5'd18, d); check(d == 0, "R8 port2 cleared", d, 0);
  endtask

  task automatic t_rd_inc();
    logic [31:0] d;
    logic [6:0]  r;
    sendCell(32'h00AB_0000, 1, r); sendCell(32'h00AB_0000, 1, r);
    @(negedge clk);
    hdrValid = 1'b1; hdrWord = 32'h00AB_0000; regRdEn = 1'b1; regAddr = 5'd16;
    @(negedge clk);
    hdrValid = 1'b0; regRdEn = 1'b0;
    check(regRdData == 2, "R10 read returns old value", regRdData, 2);
    rdReg(5'd16, d); check(d == 1, "R10 counter left at one", d, 1);
  endtask

  task automatic t_sat();
    logic [31:0] d;
    int seen = 0;
    clearCounters();
    @(negedge clk);
    hdrValid = 1'b1; hdrWord = 32'h1234_5678; hecOk = 1'b1;
    for (int i = 1; i < 65535; i++) begin
      @(negedge clk);
      if (cntOvfl != 0) seen++;
    end
    check(seen == 0, "R9 no early overflow", 32'(seen), 0);
    @(negedge clk);
    check(cntOvfl == 6'b010000, "R9 overflow pulse idle bit", 32'(cntOvfl), 32'h10);
    @(negedge clk);
    hdrValid = 1'b0;
    check(cntOvfl == 0, "R9 pulse one cycle", 32'(cntOvfl), 0);
    rdReg(5'd20, d); check(d == 32'h0000_FFFF, "R9 saturated value", d, 32'hFFFF);
    rdReg(5'd20, d); check(d == 0, "R8 cleared after saturation", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_priority();
    t_counts();
    t_rd_inc();
    t_sat();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule